// File: doc/BRIEF.md
# Instruction Prefetch Queue with Status

This block is a byte-wide first-in first-out store that decouples instruction fetching from instruction execution. A bus-fetch engine writes the bytes it has read from memory into the queue while the execution side is still busy with the current instruction, so memory latency overlaps with execution. The execution side takes one byte at a time from the head and labels each take as either the opening byte of an opcode or a later byte of the same instruction.

Every cycle, a 2-bit status output tells an outside observer, such as a coprocessor that follows the instruction stream, what the queue did in the previous clock cycle: nothing, a first-byte take, a later-byte take, or an empty-out. A flush input discards all contents when program flow changes. One parameter selects between a wide-bus variant and a narrow-bus variant. The wide-bus variant writes two bytes per write and holds six bytes. The narrow-bus variant writes one byte per write and holds four bytes.

Top module: `prefetch_queue`

## Requirements
- R1: In the cycle after reset is released, `q_status` is 2'b00, `not_empty` is 0 and `fetch_req` is 1.
- R2: A push writes `BUS_BYTES` bytes. Byte lane 0 (`push_data[7:0]`) enters first. Bytes leave in the order they entered, and `head_byte` always shows the oldest stored byte.
- R3: A push is taken only when the free space at the start of the cycle is at least `BUS_BYTES`. Otherwise the push is ignored and the stored bytes do not change, so occupancy never exceeds the depth.
- R4: `fetch_req` is high exactly when the free space is at least `BUS_BYTES` and `flush` is low. It is combinational from the stored level and `flush`.
- R5: A pop on a non-empty queue with `pop_first`=1 makes `q_status` 2'b01 in the following cycle. With `pop_first`=0 it makes `q_status` 2'b11.
- R6: `flush` takes priority over push and pop in the same cycle. It empties the queue, and `q_status` is 2'b10 in the following cycle.
- R7: A pop while `not_empty` is 0 is ignored and reports 2'b00.
- R8: A cycle with no pop and no flush reports 2'b00, even when a push is taken.
- R9: When the queue is not empty and a push fits, a push and a pop in the same cycle are both carried out. The level changes by `BUS_BYTES` minus one.
- R10: With `WIDE_BUS`=1 the depth is 6 and `BUS_BYTES` is 2. With `WIDE_BUS`=0 the depth is 4 and `BUS_BYTES` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all stored bytes |
| push | input | 1 | Write one bus word of bytes |
| push_data | input | 8*BUS_BYTES | Bytes to store; lane 0 is the oldest |
| pop | input | 1 | Take the head byte |
| pop_first | input | 1 | 1 = the taken byte opens an opcode |
| fetch_req | output | 1 | Room for one more bus word |
| not_empty | output | 1 | At least one byte is stored |
| head_byte | output | 8 | Oldest stored byte |
| q_status | output | 2 | Status of the previous cycle: 00 idle, 01 first byte, 10 flushed, 11 later byte |

## Verification
`fetch_req` is combinational, so it is checked in the same cycle as the `flush` value that drives it. `head_byte` and `not_empty` are due one edge after a push, pop or flush, and `q_status` is a register that shows the operation of the clock edge that has just passed. The bench therefore drives each step's inputs, waits for one rising edge, returns the controls to idle and only then samples all outputs. It samples well after the edge and with `flush` low, so every value it compares belongs to the step just applied.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        QS_IDLE    = 2'b00,
        QS_FIRST   = 2'b01,
        QS_FLUSHED = 2'b10,
        QS_NEXT    = 2'b11
    } qstat_e;

    typedef struct packed {
        logic flush;
        logic push;
        logic pop;
        logic first;
    } pq_op_t;

    function automatic int depth_for(input bit wide);
        return wide ? 6 : 4;
    endfunction

    function automatic int bytes_for(input bit wide);
        return wide ? 2 : 1;
    endfunction

    function automatic int wrap_add(input int p, input int k, input int depth);
        return (p + k) % depth;
    endfunction

endpackage

// File: rtl/pq_storage.sv
module pq_storage
    import pq_pkg::*;
#(
    parameter int DEPTH     = 6,
    parameter int BUS_BYTES = 2,
    parameter int PW        = 3
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [PW-1:0]          wr_ptr,
    input  logic [BUS_BYTES*8-1:0] wr_data,
    input  logic [PW-1:0]          rd_ptr,
    output logic [7:0]             rd_byte
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] lane_slot [BUS_BYTES];

    for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
        assign lane_slot[g] = PW'(wrap_add(int'(wr_ptr), g, DEPTH));
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < BUS_BYTES; i++) begin
                mem[lane_slot[i]] <= wr_data[i*8 +: 8];
            end
        end
    end

    assign rd_byte = mem[rd_ptr];
endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
    import pq_pkg::*;
#(
    parameter int DEPTH     = 6,
    parameter int BUS_BYTES = 2,
    parameter int PW        = 3,
    parameter int LW        = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  pq_op_t        op,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [LW-1:0] level,
    output logic          wr_en,
    output logic          pop_ok,
    output logic          fetch_req,
    output logic          not_empty
);
    logic room;

    assign room      = (DEPTH - int'(level)) >= BUS_BYTES;
    assign wr_en     = op.push && !op.flush && room;
    assign pop_ok    = op.pop && !op.flush && (level != '0);
    assign fetch_req = room && !op.flush;
    assign not_empty = (level != '0);

    always_ff @(posedge clk) begin
        if (rst || op.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= PW'(wrap_add(int'(wr_ptr), BUS_BYTES, DEPTH));
            end
            if (pop_ok) begin
                rd_ptr <= PW'(wrap_add(int'(rd_ptr), 1, DEPTH));
            end
            level <= LW'(int'(level) + (wr_en ? BUS_BYTES : 0) - (pop_ok ? 1 : 0));
        end
    end
endmodule

// File: rtl/pq_status.sv
module pq_status
    import pq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pq_op_t op,
    input  logic   pop_ok,
    output qstat_e status
);
    qstat_e next_status;

    always_comb begin
        if (op.flush)       next_status = QS_FLUSHED;
        else if (!pop_ok)   next_status = QS_IDLE;
        else if (op.first)  next_status = QS_FIRST;
        else                next_status = QS_NEXT;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= QS_IDLE;
        else     status <= next_status;
    end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pq_pkg::*;
#(
    parameter bit WIDE_BUS = 1'b1,
    localparam int DEPTH     = depth_for(WIDE_BUS),
    localparam int BUS_BYTES = bytes_for(WIDE_BUS),
    localparam int PW        = $clog2(DEPTH),
    localparam int LW        = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   push,
    input  logic [BUS_BYTES*8-1:0] push_data,
    input  logic                   pop,
    input  logic                   pop_first,
    output logic                   fetch_req,
    output logic                   not_empty,
    output logic [7:0]             head_byte,
    output logic [1:0]             q_status
);
    pq_op_t        op;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [LW-1:0] level;
    logic          wr_en;
    logic          pop_ok;
    qstat_e        status;

    assign op = '{flush: flush, push: push, pop: pop, first: pop_first};

    pq_ctrl #(.DEPTH(DEPTH), .BUS_BYTES(BUS_BYTES), .PW(PW), .LW(LW)) u_ctrl (
        .clk(clk), .rst(rst), .op(op), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .level(level), .wr_en(wr_en), .pop_ok(pop_ok),
        .fetch_req(fetch_req), .not_empty(not_empty)
    );

    pq_storage #(.DEPTH(DEPTH), .BUS_BYTES(BUS_BYTES), .PW(PW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(push_data),
        .rd_ptr(rd_ptr), .rd_byte(head_byte)
    );

    pq_status u_stat (
        .clk(clk), .rst(rst), .op(op), .pop_ok(pop_ok), .status(status)
    );

    assign q_status = status;
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
    parameter int DEPTH     = 6,
    parameter int BUS_BYTES = 2,
    parameter int LW        = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic          push,
    input logic          pop,
    input logic          pop_first,
    input logic          fetch_req,
    input logic          not_empty,
    input logic [1:0]    q_status,
    input logic [LW-1:0] level
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= DEPTH);

    assert_req_flush_R4: assert property (@(posedge clk) disable iff (rst)
        flush |-> !fetch_req);

    assert_first_code_R5: assert property (@(posedge clk) disable iff (rst)
        (!flush && pop && pop_first && not_empty) |=> q_status == 2'b01);

    assert_next_code_R5: assert property (@(posedge clk) disable iff (rst)
        (!flush && pop && !pop_first && not_empty) |=> q_status == 2'b11);

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (rst)
        flush |=> (q_status == 2'b10 && !not_empty));

    assert_pop_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (!flush && pop && !not_empty) |=> q_status == 2'b00);

    assert_idle_code_R8: assert property (@(posedge clk) disable iff (rst)
        (!flush && !pop) |=> q_status == 2'b00);

    assert_both_ops_R9: assert property (@(posedge clk) disable iff (rst)
        (!flush && push && pop && not_empty && (DEPTH - int'(level)) >= BUS_BYTES)
        |=> int'(level) == int'($past(level)) + BUS_BYTES - 1);
endmodule

bind prefetch_queue pq_checker #(.DEPTH(DEPTH), .BUS_BYTES(BUS_BYTES), .LW(LW)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(pop),
    .pop_first(pop_first), .fetch_req(fetch_req), .not_empty(not_empty),
    .q_status(q_status), .level(level)
);

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        push = 1'b0;
    logic [15:0] push_data = '0;
    logic        pop = 1'b0;
    logic        pop_first = 1'b0;
    logic        fetch_req;
    logic        not_empty;
    logic [7:0]  head_byte;
    logic [1:0]  q_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prefetch_queue #(.WIDE_BUS(1'b1)) uut (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .push_data(push_data),
        .pop(pop), .pop_first(pop_first), .fetch_req(fetch_req),
        .not_empty(not_empty), .head_byte(head_byte), .q_status(q_status)
    );

    typedef struct packed {
        logic        fl;
        logic        pu;
        logic [15:0] d;
        logic        po;
        logic        fi;
        logic [1:0]  st;
        logic        ne;
        logic [7:0]  hd;
        logic        rq;
    } vec_t;

    // Default variant: depth 6, two bytes per push (R10).
    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 16'h2211, 1'b0, 1'b0, 2'b00, 1'b1, 8'h11, 1'b1}, // R2 lane 0 first, R8
        '{1'b0, 1'b1, 16'h4433, 1'b1, 1'b1, 2'b01, 1'b1, 8'h22, 1'b1}, // R9, R5
        '{1'b0, 1'b1, 16'h6655, 1'b0, 1'b0, 2'b00, 1'b1, 8'h22, 1'b0}, // level 5
        '{1'b0, 1'b1, 16'h8877, 1'b0, 1'b0, 2'b00, 1'b1, 8'h22, 1'b0}, // R3 push ignored
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'b11, 1'b1, 8'h33, 1'b1}, // R5 later byte
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 2'b01, 1'b1, 8'h44, 1'b1},
        '{1'b1, 1'b1, 16'h9999, 1'b1, 1'b1, 2'b10, 1'b0, 8'h00, 1'b1}, // R6 priority
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 2'b00, 1'b0, 8'h00, 1'b1}, // R7
        '{1'b0, 1'b1, 16'hBBAA, 1'b0, 1'b0, 2'b00, 1'b1, 8'hAA, 1'b1},
        '{1'b0, 1'b1, 16'hDDCC, 1'b1, 1'b0, 2'b11, 1'b1, 8'hBB, 1'b1}, // R9
        '{1'b0, 1'b1, 16'hFFEE, 1'b1, 1'b1, 2'b01, 1'b1, 8'hCC, 1'b1},
        '{1'b0, 1'b1, 16'h1100, 1'b0, 1'b0, 2'b00, 1'b1, 8'hCC, 1'b0}, // R10 full at 6, wraps
        '{1'b0, 1'b1, 16'h3322, 1'b1, 1'b1, 2'b01, 1'b1, 8'hDD, 1'b0}, // R3 full: push dropped
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'b11, 1'b1, 8'hEE, 1'b1},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'b00, 1'b1, 8'hEE, 1'b1}, // R8 idle
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 2'b01, 1'b1, 8'hFF, 1'b1},
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'b11, 1'b1, 8'h00, 1'b1},
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'b11, 1'b1, 8'h11, 1'b1}, // R10 sixth byte out
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'b11, 1'b0, 8'h00, 1'b1},
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 2'b00, 1'b0, 8'h00, 1'b1}  // R7
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush = 1'b0; push = 1'b0; push_data = '0; pop = 1'b0; pop_first = 1'b0;
    endtask

    // Apply controls, let one edge pass, return to idle, then sample.
    task automatic step(input logic fl, input logic pu, input logic [15:0] d,
                        input logic po, input logic fi);
        flush = fl; push = pu; push_data = d; pop = po; pop_first = fi;
        @(posedge clk);
        #5;
        idle_inputs();
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 q_status", {6'd0, q_status}, 8'h00);
        check("R1 not_empty", {7'd0, not_empty}, 8'h00);
        check("R1 fetch_req", {7'd0, fetch_req}, 8'h01);

        // R4 flush held low of request on an empty queue, same cycle
        flush = 1'b1;
        #1;
        check("R4 fetch_req under flush", {7'd0, fetch_req}, 8'h00);
        @(posedge clk);
        #5 idle_inputs();
        #1;
        check("R6 flush of empty queue", {6'd0, q_status}, 8'h02);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].fl, VEC[i].pu, VEC[i].d, VEC[i].po, VEC[i].fi);
            check($sformatf("R5 status vec %0d", i), {6'd0, q_status}, {6'd0, VEC[i].st});
            check($sformatf("R2 not_empty vec %0d", i), {7'd0, not_empty}, {7'd0, VEC[i].ne});
            if (VEC[i].ne)
                check($sformatf("R2 head vec %0d", i), head_byte, VEC[i].hd);
            check($sformatf("R4 fetch_req vec %0d", i), {7'd0, fetch_req}, {7'd0, VEC[i].rq});
        end

        // R3 fill to full, then push again: contents unchanged
        step(1'b0, 1'b1, 16'hA2A1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 16'hA4A3, 1'b0, 1'b0);
        step(1'b0, 1'b1, 16'hA6A5, 1'b0, 1'b0);
        check("R3 full fetch_req", {7'd0, fetch_req}, 8'h00);
        step(1'b0, 1'b1, 16'hEEEE, 1'b0, 1'b0);
        for (int k = 1; k <= 6; k++) begin
            check("R3 order after dropped push", head_byte, 8'hA0 + 8'(k));
            step(1'b0, 1'b0, 16'h0000, 1'b1, (k == 1));
        end
        check("R10 empty after six pops", {7'd0, not_empty}, 8'h00);

        // R6 flush mid-stream, then fresh data shows at head
        step(1'b0, 1'b1, 16'h5150, 1'b0, 1'b0);
        step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
        check("R6 flush clears", {7'd0, not_empty}, 8'h00);
        step(1'b0, 1'b1, 16'h7170, 1'b0, 1'b0);
        check("R6 head after flush", head_byte, 8'h70);

        // R1 reset in the middle of operation
        rst = 1'b1;
        step(1'b0, 1'b0, 16'h0000, 1'b1, 1'b1);
        rst = 1'b0;
        check("R1 reset clears not_empty", {7'd0, not_empty}, 8'h00);
        check("R1 reset clears status", {6'd0, q_status}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule